// File: doc/BRIEF.md
# Real-time clock event and status flag register

This block is the status register of a real-time clock. The neighbouring clock logic hands it single-cycle strobes: two tamper detections, a timestamp capture, expiry of the wakeup reload counter, a match for each of two alarms, and completion of a copy of the calendar into the shadow registers. Each strobe is caught in a sticky flag. Software reads the flags over a plain write-enable/data register port and clears a flag by writing 0 to its bit. If a timestamp arrives while the previous one is still flagged, an overflow flag is raised.

The same register holds the request to enter initialization mode. An acknowledge bit reports when that mode has been reached. While the request is set, the calendar counters are held stopped. Calendar and prescaler writes are allowed only while the acknowledge bit is high.

Top module: `rtc_flag_reg`

## Requirements
- R1: After an active-low reset, every bit of `rd_data_o` is 0, `counters_run_o` is 1 and `cal_wr_en_o` is 0.
- R2: A one-cycle strobe on an event input sets its flag, which is visible on `rd_data_o` after the next rising clock edge. Bit positions: 8 alarm A, 9 alarm B, 10 wakeup, 11 timestamp, 13 tamper 1, 14 tamper 2.
- R3: A write with bit b equal to 0 clears event flag b (bits 8 to 14). A write with bit b equal to 1 leaves the flag unchanged.
- R4: When a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up as 1.
- R5: A timestamp strobe that arrives while bit 11 already reads 1 sets the overflow flag at bit 12. The overflow flag follows the clear rules of R3 and R4.
- R6: Bit 7 (init request) takes the value of bit 7 on every write and otherwise holds its value. `counters_run_o` is the inverse of bit 7.
- R7: Bit 6 (init acknowledge) rises on the second rising edge after bit 7 became 1. It reads 0 in the same cycle that bit 7 reads 0. Writes do not change it. `cal_wr_en_o` equals bit 6.
- R8: Bit 5 (synchronized) is cleared by hardware on the next edge whenever bit 7, `shift_pend_i` or `shadow_bypass_i` is 1, and this takes priority over everything else. Otherwise `shadow_copy_i` sets it, taking priority over a software write of 0. A write of 1 has no effect on it.
- R9: Bits 15 and 4 to 0 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Current register value |
| tamp2_evt_i | input | 1 | Tamper input 2 event strobe |
| tamp1_evt_i | input | 1 | Tamper input 1 event strobe |
| ts_evt_i | input | 1 | Timestamp event strobe |
| wakeup_evt_i | input | 1 | Wakeup counter reached zero |
| alarm_b_evt_i | input | 1 | Alarm B match strobe |
| alarm_a_evt_i | input | 1 | Alarm A match strobe |
| shadow_copy_i | input | 1 | Calendar copied into shadow registers |
| shift_pend_i | input | 1 | Sub-second shift operation pending |
| shadow_bypass_i | input | 1 | Shadow registers bypassed |
| counters_run_o | output | 1 | Calendar counters may advance |
| cal_wr_en_o | output | 1 | Calendar and prescaler writes permitted |

## Verification
The main hazard is a hardware event that sets a flag in the same cycle that software writes 0 to clear it. A second case is a timestamp strobe that coincides with the clear of the timestamp flag, which must still raise the overflow flag. Directed steps build both collisions on purpose. Random traffic then drives event strobes together with writes carrying random data, so collisions also occur on every flag and on the synchronized bit against its hardware-clear conditions. A bench model applies set-over-clear and clear-over-copy priority and judges every bit field after each edge.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned N_EVT   = 6;
  // bit positions decoded by software
  localparam int unsigned POS_TAMP2 = 14;
  localparam int unsigned POS_TAMP1 = 13;
  localparam int unsigned POS_TSOVR = 12;
  localparam int unsigned POS_TS    = 11;
  localparam int unsigned POS_WAKE  = 10;
  localparam int unsigned POS_ALMB  = 9;
  localparam int unsigned POS_ALMA  = 8;
  localparam int unsigned POS_IREQ  = 7;
  localparam int unsigned POS_IACK  = 6;
  localparam int unsigned POS_SYNC  = 5;

  // event index -> register bit; index order {tamp2,tamp1,ts,wake,almb,alma}
  function automatic int unsigned evt_pos(input int unsigned idx);
    case (idx)
      0:       evt_pos = POS_ALMA;
      1:       evt_pos = POS_ALMB;
      2:       evt_pos = POS_WAKE;
      3:       evt_pos = POS_TS;
      4:       evt_pos = POS_TAMP1;
      default: evt_pos = POS_TAMP2;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_init_hs.sv
module rtc_init_hs #(
  parameter int unsigned ACK_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic req_wdata_i,
  output logic req_o,
  output logic ack_o
);
  localparam int unsigned CW = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(ACK_DLY);

  logic          req_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      req_q <= 1'b0;
    else if (wr_en_i) req_q <= req_wdata_i;
  end

  // restarts whenever the request was low, so a short drop re-arms the delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!req_q)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
  end

  assign req_o = req_q;
  assign ack_o = req_q && (cnt_q == CNT_MAX);
endmodule

// File: rtl/rtc_sync_flag.sv
module rtc_sync_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_clr_i,
  input  logic copy_i,
  input  logic sw_clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (hw_clr_i) q_o <= 1'b0;
    else if (copy_i)   q_o <= 1'b1;
    else if (sw_clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_flag_pkg::*;
#(
  parameter int unsigned ACK_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             tamp2_evt_i,
  input  logic             tamp1_evt_i,
  input  logic             ts_evt_i,
  input  logic             wakeup_evt_i,
  input  logic             alarm_b_evt_i,
  input  logic             alarm_a_evt_i,
  input  logic             shadow_copy_i,
  input  logic             shift_pend_i,
  input  logic             shadow_bypass_i,
  output logic             counters_run_o,
  output logic             cal_wr_en_o
);
  logic [N_EVT-1:0] evt_strb;
  logic [N_EVT-1:0] evt_q;
  logic             ovr_q, ireq, iack, sync_q;
  logic             unused_wr_bits;

  assign evt_strb = {tamp2_evt_i, tamp1_evt_i, ts_evt_i,
                     wakeup_evt_i, alarm_b_evt_i, alarm_a_evt_i};

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    rtc_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_strb[i]),
      .clr_i  (wr_en_i && !wr_data_i[evt_pos(i)]),
      .q_o    (evt_q[i])
    );
  end

  // overflow judged against the flag value before this edge
  rtc_sticky_flag u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ts_evt_i && evt_q[3]),
    .clr_i  (wr_en_i && !wr_data_i[POS_TSOVR]),
    .q_o    (ovr_q)
  );

  rtc_init_hs #(.ACK_DLY(ACK_DLY)) u_init (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .req_wdata_i (wr_data_i[POS_IREQ]),
    .req_o       (ireq),
    .ack_o       (iack)
  );

  rtc_sync_flag u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_clr_i (ireq || shift_pend_i || shadow_bypass_i),
    .copy_i   (shadow_copy_i),
    .sw_clr_i (wr_en_i && !wr_data_i[POS_SYNC]),
    .q_o      (sync_q)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < int'(N_EVT); i++) rd_data_o[evt_pos(i)] = evt_q[i];
    rd_data_o[POS_TSOVR] = ovr_q;
    rd_data_o[POS_IREQ]  = ireq;
    rd_data_o[POS_IACK]  = iack;
    rd_data_o[POS_SYNC]  = sync_q;
  end

  assign counters_run_o = !ireq;
  assign cal_wr_en_o    = iack;
  assign unused_wr_bits = ^wr_data_i;
endmodule

// File: rtl/rtc_flag_reg_chk.sv
module rtc_flag_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        tamp2_evt_i,
  input logic        ts_evt_i,
  input logic        alarm_a_evt_i,
  input logic        shift_pend_i,
  input logic        shadow_bypass_i,
  input logic        counters_run_o,
  input logic        cal_wr_en_o
);
  a_r2_alarm_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_a_evt_i |=> rd_data_o[8]);
  a_r3_write_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[9] && rd_data_o[9]) |=> rd_data_o[9]);
  a_r4_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[14] && tamp2_evt_i) |=> rd_data_o[14]);
  a_r5_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_evt_i && rd_data_o[11]) |=> rd_data_o[12]);
  a_r6_run_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counters_run_o == !rd_data_o[7]);
  a_r7_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[7] |-> !rd_data_o[6]);
  a_r7_ack_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[7]) |-> !rd_data_o[6]);
  a_r7_wr_en_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_en_o == rd_data_o[6]);
  a_r8_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7] || shift_pend_i || shadow_bypass_i) |=> !rd_data_o[5]);
  a_r9_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[15] && (rd_data_o[4:0] == 5'd0));
endmodule

bind rtc_flag_reg rtc_flag_reg_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .rd_data_o       (rd_data_o),
  .tamp2_evt_i     (tamp2_evt_i),
  .ts_evt_i        (ts_evt_i),
  .alarm_a_evt_i   (alarm_a_evt_i),
  .shift_pend_i    (shift_pend_i),
  .shadow_bypass_i (shadow_bypass_i),
  .counters_run_o  (counters_run_o),
  .cal_wr_en_o     (cal_wr_en_o)
);

// File: tb/rtc_flag_reg_tb.sv
module rtc_flag_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        tamp2_evt_i = 0, tamp1_evt_i = 0, ts_evt_i = 0, wakeup_evt_i = 0;
  logic        alarm_b_evt_i = 0, alarm_a_evt_i = 0;
  logic        shadow_copy_i = 0, shift_pend_i = 0, shadow_bypass_i = 0;
  logic        counters_run_o, cal_wr_en_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q = '0;
  int          age = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rtc_flag_reg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .tamp2_evt_i(tamp2_evt_i), .tamp1_evt_i(tamp1_evt_i),
    .ts_evt_i(ts_evt_i), .wakeup_evt_i(wakeup_evt_i), .alarm_b_evt_i(alarm_b_evt_i),
    .alarm_a_evt_i(alarm_a_evt_i), .shadow_copy_i(shadow_copy_i),
    .shift_pend_i(shift_pend_i), .shadow_bypass_i(shadow_bypass_i),
    .counters_run_o(counters_run_o), .cal_wr_en_o(cal_wr_en_o));

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mdl_next(input logic [15:0] cur, input logic [5:0] ev,
      input logic cp, input logic sh, input logic by, input logic wr,
      input logic [15:0] wd);
    logic [15:0] n;
    int pos [6] = '{8, 9, 10, 11, 13, 14};
    n = '0;
    for (int i = 0; i < 6; i++)
      n[pos[i]] = ev[i] | (cur[pos[i]] & !(wr & !wd[pos[i]]));
    n[12] = (ev[3] & cur[11]) | (cur[12] & !(wr & !wd[12]));
    n[7]  = wr ? wd[7] : cur[7];
    if (cur[7] | sh | by) n[5] = 1'b0;
    else if (cp)          n[5] = 1'b1;
    else if (wr & !wd[5]) n[5] = 1'b0;
    else                  n[5] = cur[5];
    return n;
  endfunction

  task automatic compare_all();
    logic [15:0] m;
    m = 16'h6F00;
    chk((rd_data_o & m) == (exp_q & m), "R2 event flags", rd_data_o & m, exp_q & m);
    chk(rd_data_o[12] == exp_q[12], "R5 overflow", {15'd0, rd_data_o[12]}, {15'd0, exp_q[12]});
    chk(rd_data_o[7] == exp_q[7], "R6 init request", {15'd0, rd_data_o[7]}, {15'd0, exp_q[7]});
    chk(counters_run_o == !exp_q[7], "R6 counters_run", {15'd0, counters_run_o}, {15'd0, !exp_q[7]});
    chk(rd_data_o[6] == exp_q[6], "R7 init ack", {15'd0, rd_data_o[6]}, {15'd0, exp_q[6]});
    chk(cal_wr_en_o == exp_q[6], "R7 cal_wr_en", {15'd0, cal_wr_en_o}, {15'd0, exp_q[6]});
    chk(rd_data_o[5] == exp_q[5], "R8 sync flag", {15'd0, rd_data_o[5]}, {15'd0, exp_q[5]});
    chk((rd_data_o & 16'h801F) == 16'h0, "R9 unused bits", rd_data_o & 16'h801F, 16'h0);
  endtask

  // ev order {tamp2,tamp1,ts,wake,almb,alma}; called just after a falling edge
  task automatic step(input logic [5:0] ev, input logic cp, input logic sh,
                      input logic by, input logic wr, input logic [15:0] wd);
    {tamp2_evt_i, tamp1_evt_i, ts_evt_i, wakeup_evt_i, alarm_b_evt_i, alarm_a_evt_i} = ev;
    shadow_copy_i = cp; shift_pend_i = sh; shadow_bypass_i = by;
    wr_en_i = wr; wr_data_i = wd;
    age = exp_q[7] ? ((age < 2) ? age + 1 : 2) : 0;
    exp_q = mdl_next(exp_q, ev, cp, sh, by, wr, wd);
    exp_q[6] = exp_q[7] && (age == 2);
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(rd_data_o == 16'h0, "R1 reset rd_data", rd_data_o, 16'h0);
    chk(counters_run_o && !cal_wr_en_o, "R1 reset outputs",
        {14'd0, counters_run_o, cal_wr_en_o}, 16'h0002);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 each event individually
    for (int i = 0; i < 6; i++) step(6'b1 << i, 0, 0, 0, 0, '0);
    chk(rd_data_o[14:8] == 7'b1101111, "R2 all events set", rd_data_o, 16'h6F00);
    // R3 write ones keeps, write zeros clears
    step('0, 0, 0, 0, 1, 16'h7F00);
    chk(rd_data_o[14:8] == 7'b1101111, "R3 write one keeps", rd_data_o, 16'h6F00);
    step('0, 0, 0, 0, 1, 16'h0000);
    chk(rd_data_o[14:8] == 7'b0, "R3 write zero clears", rd_data_o, 16'h0);
    // R4 collision of set and clear
    step(6'b100000, 0, 0, 0, 1, 16'h0000);
    chk(rd_data_o[14], "R4 set wins", rd_data_o, 16'h4000);
    // R5 overflow, including ts clear colliding with ts event
    step(6'b001000, 0, 0, 0, 0, '0);
    chk(!rd_data_o[12], "R5 no overflow on first", rd_data_o, 16'h0800);
    step(6'b001000, 0, 0, 0, 1, 16'h0000);
    chk(rd_data_o[12] && rd_data_o[11], "R5 overflow on second", rd_data_o, 16'h1800);
    step('0, 0, 0, 0, 1, 16'h0000);
    // R8 sync flag
    step('0, 1, 0, 0, 0, '0);
    chk(rd_data_o[5], "R8 copy sets", rd_data_o, 16'h0020);
    step('0, 1, 0, 0, 1, 16'h0000);
    chk(rd_data_o[5], "R8 copy beats sw clear", rd_data_o, 16'h0020);
    step('0, 1, 1, 0, 0, '0);
    chk(!rd_data_o[5], "R8 shift clears", rd_data_o, 16'h0);
    // R7 init handshake timing
    step('0, 0, 0, 0, 1, 16'h0080);
    chk(rd_data_o[7] && !rd_data_o[6] && !counters_run_o, "R7 ack not yet", rd_data_o, 16'h0080);
    step('0, 0, 0, 0, 0, '0);
    chk(!rd_data_o[6], "R7 ack after one edge", rd_data_o, 16'h0080);
    step('0, 0, 0, 0, 0, '0);
    chk(rd_data_o[6] && cal_wr_en_o, "R7 ack after two edges", rd_data_o, 16'h00C0);
    step('0, 1, 0, 0, 1, 16'h00C0);
    chk(!rd_data_o[5], "R8 init blocks copy", rd_data_o, 16'h00C0);
    step('0, 0, 0, 0, 1, 16'h0040);
    chk(!rd_data_o[6] && !rd_data_o[7], "R7 ack drops with request", rd_data_o, 16'h0);
    // R9 unused bits
    step('0, 0, 0, 0, 1, 16'hFFFF);
    chk((rd_data_o & 16'h801F) == 0, "R9 unused ignore writes", rd_data_o, 16'h0080);
    step('0, 0, 0, 0, 1, 16'h0000);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] ev;
      logic wr;
      ev = 6'($urandom) & 6'($urandom);
      wr = ($urandom % 4) == 0;
      step(ev, 1'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0, wr,
           16'($urandom) & (($urandom % 3 == 0) ? 16'hFFFF : 16'hFF7F));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule